// File: doc/BRIEF.md
# Two-Wire Memory Slave with Page Wrap

This block is the slave end of a two-wire serial bus, built to sit in front of a small byte-addressed memory that commits writes in a slow nonvolatile cycle. It watches the clock and data lines by sampling them on the system clock. It finds the bus conditions that open and close a transfer, checks the address byte against its device-select inputs, and answers on the data line through a single drive-low enable. The line itself is open-drain and pulled up outside the block.

The memory side sees a plain request interface. There is one write strobe per received data byte, one read strobe per byte about to be sent, and a single commit pulse when a write transfer closes. While the memory reports that its write cycle is still running, the slave refuses its own address. A master can therefore poll until it is acknowledged again. Each data byte of a write steps only the low address bits, so a burst stays inside one page and wraps around within it. A read walks the whole address space.

Top module: `twowire_page_slave`

## Requirements
- R1: A falling data line while the clock line is high starts address reception from any state and releases the data line. A rising data line while the clock is high returns the slave to idle with the data line released.
- R2: The address byte is acknowledged when bits 7:4 equal 1010 and bits 3:1 equal `dev_sel`. Bit 0 selects the direction, with 1 meaning read. The acknowledge is the data line held low for the ninth clock of the byte.
- R3: When the type or device bits do not match, the slave does not acknowledge. It then acknowledges nothing, drives nothing and issues no memory request until the next start.
- R4: While `nv_busy` is high as the address byte completes, the address is not acknowledged for either direction. Acknowledges resume once `nv_busy` is low.
- R5: In a write, the byte after the address byte loads the 8-bit pointer and is acknowledged. Each following data byte is acknowledged and produces one `mem_wr` at the pointer. After that write, only the low 4 pointer bits advance, modulo 16.
- R6: When more than 16 data bytes arrive, later bytes overwrite earlier ones in the same page. `mem_commit` pulses once, at the stop, only if at least one data byte was taken since the last start. A transfer cut short by a repeated start commits nothing.
- R7: A read is started by sending the pointer in a write, then a repeated start and a read address. Bytes are then sent MSB first from the pointer, and the full 8-bit pointer advances by one per byte, wrapping from FFh to 00h. Sending continues for as long as the master acknowledges.
- R8: If the master does not acknowledge a sent byte, the slave stops driving and stays off the line until the next start.
- R9: The drive-low enable changes only while the clock line is low. It is released during the ninth clock of every byte the slave sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin (wired value) |
| dev_sel | input | 3 | Device-select bits compared with address bits 3:1 |
| sda_drive_low | output | 1 | When high, the pad pulls the data line low |
| mem_wr | output | 1 | One-cycle write strobe for a received data byte |
| mem_rd | output | 1 | One-cycle read strobe; `mem_rdata` is used from the next cycle |
| mem_addr | output | 8 | Byte address for `mem_wr` or `mem_rd` |
| mem_wdata | output | 8 | Data byte for `mem_wr` |
| mem_rdata | input | 8 | Read data, held by the memory side until the next `mem_rd` |
| mem_commit | output | 1 | One-cycle pulse at a stop that closes a write with data |
| nv_busy | input | 1 | Memory side is in its nonvolatile write cycle |

## Verification
The two functions that can meet in one cycle are the evaluation of a completed address byte and the fall of `nv_busy` at the end of a write cycle. The bench provokes this by polling with address bytes right after a committing stop, for both directions, until one is acknowledged. Each poll is judged against the busy level the bench's memory model holds as that byte ends. A refused poll must have seen busy high, and the first acknowledge must come only after busy is low. A bound property also checks that no acknowledge ever follows an address byte evaluated under busy.

// File: rtl/twowire_page_slave.sv
module twowire_page_slave #(
  parameter int          PAGE_BITS = 4,
  parameter logic [3:0]  TYPE_ID   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] dev_sel,
  output logic       sda_drive_low,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  input  logic [7:0] mem_rdata,
  output logic       mem_commit,
  input  logic       nv_busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WORD, S_WDATA, S_ACK, S_RDATA, S_RACK
  } st_t;

  st_t        st, after;
  logic [2:0] scl_sh, sda_sh;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr;
  logic       wrote, drive, master_ack;

  wire scl_s = scl_sh[1];
  wire scl_q = scl_sh[2];
  wire sda_s = sda_sh[1];
  wire sda_q = sda_sh[2];

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_done = scl_fall && (bitcnt == 4'd8);
  wire addr_hit  = (sh[7:4] == TYPE_ID) && (sh[3:1] == dev_sel) && !nv_busy;
  wire addr_eval = (st == S_ADDR) && byte_done && !start_det && !stop_det;

  assign sda_drive_low = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      after      <= S_IDLE;
      bitcnt     <= '0;
      sh         <= '0;
      ptr        <= '0;
      wrote      <= 1'b0;
      drive      <= 1'b0;
      master_ack <= 1'b0;
      mem_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_commit <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_commit <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        bitcnt <= '0;
        drive  <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        drive      <= 1'b0;
        mem_commit <= wrote;
        wrote      <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WORD, S_WDATA: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              if (st == S_ADDR) begin
                if (addr_hit) begin
                  drive <= 1'b1;
                  st    <= S_ACK;
                  if (sh[0]) begin
                    after    <= S_RDATA;
                    mem_rd   <= 1'b1;
                    mem_addr <= ptr;
                  end else begin
                    after <= S_WORD;
                  end
                end else begin
                  st <= S_IDLE;
                end
              end else if (st == S_WORD) begin
                ptr   <= sh;
                drive <= 1'b1;
                st    <= S_ACK;
                after <= S_WDATA;
              end else begin
                mem_wr    <= 1'b1;
                mem_addr  <= ptr;
                mem_wdata <= sh;
                ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
                wrote <= 1'b1;
                drive <= 1'b1;
                st    <= S_ACK;
                after <= S_WDATA;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              st     <= after;
              if (after == S_RDATA) begin
                sh    <= mem_rdata;
                drive <= ~mem_rdata[7];
                ptr   <= ptr + 8'd1;
              end else begin
                drive <= 1'b0;
              end
            end
          end
          S_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                drive <= 1'b0;
                st    <= S_RACK;
              end else begin
                sh    <= {sh[6:0], 1'b0};
                drive <= ~sh[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_s;
              if (!sda_s) begin
                mem_rd   <= 1'b1;
                mem_addr <= ptr;
              end
            end else if (scl_fall) begin
              if (master_ack) begin
                sh     <= mem_rdata;
                drive  <= ~mem_rdata[7];
                ptr    <= ptr + 8'd1;
                bitcnt <= '0;
                st     <= S_RDATA;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twowire_page_slave_chk.sv
module twowire_page_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_drive_low,
  input logic mem_wr,
  input logic mem_rd,
  input logic mem_commit,
  input logic nv_busy,
  input logic stop_det,
  input logic addr_eval
);

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low); // R1

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eval && nv_busy) |=> !sda_drive_low); // R4

  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd)); // R5

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |=> !mem_commit); // R6

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_in); // R9

endmodule

bind twowire_page_slave twowire_page_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_drive_low(sda_drive_low),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_commit(mem_commit), .nv_busy(nv_busy),
  .stop_det(stop_det), .addr_eval(addr_eval)
);

// File: tb/twowire_page_slave_tb.sv
module twowire_page_slave_tb;

  localparam int QC = 6;
  localparam int BUSY_CYC = 1500;
  localparam logic [2:0] DEV = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b1010, DEV, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b1010, DEV, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_drive_low, mem_wr, mem_rd, mem_commit, nv_busy;
  logic [7:0] mem_addr, mem_wdata, rdata_q;
  logic [7:0] mem_arr [256];
  logic [7:0] model [256];
  int busy_cnt = 0;
  int n_wr = 0, n_rd = 0, n_commit = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;
  assign nv_busy = (busy_cnt != 0);

  twowire_page_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .dev_sel(DEV),
    .sda_drive_low(sda_drive_low), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
    .mem_commit(mem_commit), .nv_busy(nv_busy)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= 8'(i * 7 + 3);
      rdata_q <= 8'h00;
      busy_cnt <= 0;
    end else begin
      if (mem_wr) begin mem_arr[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
      if (mem_rd) begin rdata_q <= mem_arr[mem_addr]; n_rd <= n_rd + 1; end
      if (mem_commit) begin busy_cnt <= BUSY_CYC; n_commit <= n_commit + 1; end
      else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QC) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    sda_m = b; wq();
    scl = 1'b1; wq();
    r = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bitx(b[i], r);
    bitx(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, r); d = {d[6:0], r}; end
    sda_m = ~give_ack; wq();
    scl = 1'b1; wq();
    chk("R9 slave off the line in ack slot", {31'd0, sda_drive_low}, 32'd0);
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic wait_idle();
    while (nv_busy) @(negedge clk);
    wq();
  endtask

  // opens a write, sets the pointer and sends n data bytes; caller closes
  task automatic page_write(input logic [7:0] a, input int n, input bit rnd);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte(ADDR_W, ak); chk("R2 write address ack", {31'd0, ak}, 32'd1);
    send_byte(a, ak);      chk("R5 pointer byte ack", {31'd0, ak}, 32'd1);
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : 8'(8'h40 + i);
      send_byte(d, ak);    chk("R5 data byte ack", {31'd0, ak}, 32'd1);
      model[{a[7:4], 4'(a[3:0] + i)}] = d;
    end
  endtask

  task automatic read_seq(input logic [7:0] a, input int n);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte(ADDR_W, ak); chk("R2 write address ack", {31'd0, ak}, 32'd1);
    send_byte(a, ak);      chk("R7 pointer byte ack", {31'd0, ak}, 32'd1);
    bus_start();
    send_byte(ADDR_R, ak); chk("R2 read address ack", {31'd0, ak}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk($sformatf("R7 read data at %0h", 8'(a + i)), {24'd0, d}, {24'd0, model[8'(a + i)]});
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic ak, r;
    logic [7:0] d;
    int c0, w0, polls;
    bit got;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) model[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset: line released", {31'd0, sda_drive_low}, 32'd0);
    chk("R1 reset: no memory strobes", n_wr + n_rd + n_commit, 32'd0);

    // R5/R6: 12 bytes from offset 11 wrap, then repeated start reads the pointer left at 7
    c0 = n_commit; w0 = n_wr;
    page_write(8'h2B, 12, 1'b0);
    bus_start();
    send_byte(ADDR_R, ak); chk("R2 read address ack", {31'd0, ak}, 32'd1);
    recv_byte(1'b0, d);
    chk("R5 pointer left at offset 7", {24'd0, d}, {24'd0, model[8'h27]});
    bus_stop();
    chk("R1 line released after stop", {31'd0, sda_drive_low}, 32'd0);
    chk("R5 one write strobe per data byte", n_wr - w0, 32'd12);
    chk("R6 no commit after repeated start", n_commit - c0, 32'd0);
    read_seq(8'h20, 16);

    // R6: 20 bytes overwrite within the page, one commit at stop
    c0 = n_commit;
    page_write(8'h54, 20, 1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R6 single commit at stop", n_commit - c0, 32'd1);

    // R4: polling while the write cycle runs
    bus_start();
    send_byte(ADDR_W, ak); chk("R4 write address refused while busy", {31'd0, ak}, 32'd0);
    bus_stop();
    bus_start();
    send_byte(ADDR_R, ak); chk("R4 read address refused while busy", {31'd0, ak}, 32'd0);
    bus_stop();
    polls = 0; got = 1'b0;
    while (!got && polls < 20) begin
      bus_start();
      send_byte(ADDR_W, ak);
      if (ak) begin
        got = 1'b1;
        chk("R4 acknowledge only after busy ends", {31'd0, nv_busy}, 32'd0);
      end else begin
        chk("R4 refusal only while busy", {31'd0, nv_busy}, 32'd1);
      end
      bus_stop();
      polls++;
    end
    chk("R4 polling eventually acknowledged", {31'd0, got}, 32'd1);
    read_seq(8'h50, 16);

    // R3: wrong device bits, then wrong type field
    w0 = n_wr; c0 = n_rd;
    bus_start();
    send_byte({4'b1010, 3'b011, 1'b0}, ak); chk("R3 wrong device refused", {31'd0, ak}, 32'd0);
    send_byte(8'h10, ak); chk("R3 following byte ignored", {31'd0, ak}, 32'd0);
    send_byte(8'h99, ak); chk("R3 data ignored", {31'd0, ak}, 32'd0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, DEV, 1'b1}, ak); chk("R3 wrong type refused", {31'd0, ak}, 32'd0);
    recv_byte(1'b1, d); chk("R3 slave silent after refusal", {24'd0, d}, 32'hFF);
    bus_stop();
    chk("R3 no memory requests", (n_wr - w0) + (n_rd - c0), 32'd0);

    // R7: read pointer wraps across FFh
    read_seq(8'hFE, 3);

    // R8: master nack ends sending
    bus_start();
    send_byte(ADDR_W, ak);
    send_byte(8'h03, ak);
    bus_start();
    send_byte(ADDR_R, ak); chk("R2 read address ack", {31'd0, ak}, 32'd1);
    recv_byte(1'b0, d); chk("R7 single read byte", {24'd0, d}, {24'd0, model[8'h03]});
    c0 = n_rd;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, r); d = {d[6:0], r}; end
    bitx(1'b1, r);
    chk("R8 line stays high after nack", {24'd0, d}, 32'hFF);
    chk("R8 no further reads after nack", n_rd - c0, 32'd0);
    bus_stop();

    // random page writes and read-back
    for (int it = 0; it < 6; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = 1 + int'($urandom_range(19, 0));
      c0 = n_commit;
      page_write(a, n, 1'b1);
      bus_stop();
      repeat (4) @(negedge clk);
      chk("R6 random write commits once", n_commit - c0, 32'd1);
      wait_idle();
      read_seq({a[7:4], 4'h0}, 16);
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule